// File: doc/BRIEF.md
# Nested Interrupt Level Gate

This block sits between a set of prioritized interrupt sources and a processor core that lets a handler be interrupted by a more urgent one. Each source line carries a programmable 3-bit priority. Level 0 turns the source off, and level 7 is the most urgent. The block picks the most urgent pending source. It lets that source through only at an instruction boundary, only when the core is not already inside exception entry, only when software has enabled interrupts, and only when the source outranks the level being serviced now.

When a request is let through, the block records the return address, raises its current-level mask to the level it accepted, and sets its exception-level flag so that no second entry happens. A return-from-exception pulse clears the flag. Software reaches the mask, the two status flags and the saved return address through a small register port. A handler can clear the exception-level flag to allow nesting. Before returning, it sets the flag again and restores the mask it saved earlier.

Top module: `irq_level_gate`

## Requirements
- R1: When a request is accepted, the current-level mask takes the level of the accepted source at the same clock edge.
- R2: A request is accepted only if its level is strictly greater than the current-level mask. An equal or lower level is never accepted.
- R3: Acceptance sets the exception-level flag to 1. While that flag is 1, no request is accepted.
- R4: A return pulse (`eret_i` high for one cycle) clears the exception-level flag at the next edge, unless an acceptance happens at that same edge.
- R5: A request is accepted only while the interrupt-enable flag is 1. Only a software write changes this flag.
- R6: On acceptance, `pc_i` is captured as the saved return address. A later acceptance overwrites it.
- R7: The winning source is the one with the highest nonzero level whose request line is high. On a tie, the lowest index wins. A source at level 0 is never chosen.
- R8: A request is accepted only in a cycle in which `retire_i` is high.
- R9: Register port, at word address `reg_addr_i`. Address 0 is status, with enable in bit 0 and exception-level in bit 1. Address 1 is the mask, in bits 2:0. Address 2 is the saved return address and is read-only, so writes to it are ignored. Address 3 reads as zero. A write takes effect at the clock edge. An acceptance or return pulse at that same edge overrides it. `reg_rdata_o` reflects the addressed register combinationally.
- R10: `take_o` is a registered pulse, high in the cycle after the acceptance decision and never for two cycles in a row. `take_id_o` and `take_lvl_o` give the source index and level while `take_o` is high, and are zero otherwise.
- R11: After reset, the mask is 0, both flags are 0, the saved return address is 0 and `take_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_i | input | N_SRC | Request line per source |
| prio_i | input | N_SRC*LVL_W | Level per source; source i at bits [i*LVL_W +: LVL_W] |
| retire_i | input | 1 | An instruction boundary this cycle |
| pc_i | input | PC_W | Address to resume at if interrupted now |
| eret_i | input | 1 | Return-from-exception pulse |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register word address |
| reg_wdata_i | input | PC_W | Register write data |
| reg_rdata_o | output | PC_W | Register read data |
| take_o | output | 1 | Acceptance pulse |
| take_id_o | output | $clog2(N_SRC) | Accepted source index |
| take_lvl_o | output | LVL_W | Accepted source level |

## Verification
The acceptance decision is made from the inputs and the register state during a cycle. `take_o`, its index and level, the mask, both flags and the saved address all change at the next rising edge. `reg_rdata_o` then shows the new state for the address held on the port, with no further delay. The bench applies inputs on the falling edge and steps a model of the same rules at the rising edge. It compares every output one time unit after that edge, so each result is checked in the first cycle it is due.

// File: rtl/irq_gate_pkg.sv
package irq_gate_pkg;
  localparam logic [1:0] RA_STATUS = 2'd0;
  localparam logic [1:0] RA_MASK   = 2'd1;
  localparam logic [1:0] RA_EPC    = 2'd2;
  localparam int ST_IE_BIT  = 0;
  localparam int ST_EXL_BIT = 1;

  // true when a candidate level strictly outranks the level being serviced
  function automatic logic outranks(input logic [7:0] cand, input logic [7:0] cur);
    return cand > cur;
  endfunction
endpackage

// File: rtl/irq_pick.sv
module irq_pick #(
  parameter int N_SRC = 8,
  parameter int LVL_W = 3,
  localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic [N_SRC-1:0]       req_i,
  input  logic [N_SRC*LVL_W-1:0] prio_i,
  output logic                   any_o,
  output logic [IDX_W-1:0]       idx_o,
  output logic [LVL_W-1:0]       lvl_o
);
  logic [LVL_W-1:0] best_lvl;
  logic [IDX_W-1:0] best_idx;

  // a strict compare keeps the earliest index on a tie and never picks level 0
  always_comb begin
    best_lvl = '0;
    best_idx = '0;
    for (int i = 0; i < N_SRC; i++) begin
      if (req_i[i] && (prio_i[i*LVL_W +: LVL_W] > best_lvl)) begin
        best_lvl = prio_i[i*LVL_W +: LVL_W];
        best_idx = IDX_W'(i);
      end
    end
  end

  assign any_o = (best_lvl != '0);
  assign idx_o = best_idx;
  assign lvl_o = best_lvl;
endmodule

// File: rtl/irq_state.sv
module irq_state
  import irq_gate_pkg::*;
#(
  parameter int LVL_W = 3,
  parameter int PC_W  = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept_i,
  input  logic [LVL_W-1:0] acc_lvl_i,
  input  logic [PC_W-1:0]  pc_i,
  input  logic             eret_i,
  input  logic             we_i,
  input  logic [1:0]       addr_i,
  input  logic [PC_W-1:0]  wdata_i,
  output logic [LVL_W-1:0] mask_o,
  output logic             exl_o,
  output logic             ie_o,
  output logic [PC_W-1:0]  epc_o,
  output logic [PC_W-1:0]  rdata_o
);
  logic wr_status, wr_mask;
  assign wr_status = we_i && (addr_i == RA_STATUS);
  assign wr_mask   = we_i && (addr_i == RA_MASK);

  // precedence at one edge: software write, then return pulse, then acceptance
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_o <= '0;
      exl_o  <= 1'b0;
      ie_o   <= 1'b0;
      epc_o  <= '0;
    end else begin
      if (wr_status) begin
        ie_o  <= wdata_i[ST_IE_BIT];
        exl_o <= wdata_i[ST_EXL_BIT];
      end
      if (wr_mask) mask_o <= wdata_i[LVL_W-1:0];
      if (eret_i) exl_o <= 1'b0;
      if (accept_i) begin
        mask_o <= acc_lvl_i;
        exl_o  <= 1'b1;
        epc_o  <= pc_i;
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      RA_STATUS: begin
        rdata_o[ST_IE_BIT]  = ie_o;
        rdata_o[ST_EXL_BIT] = exl_o;
      end
      RA_MASK: rdata_o[LVL_W-1:0] = mask_o;
      RA_EPC:  rdata_o = epc_o;
      default: rdata_o = '0;
    endcase
  end

  assert_eret_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (eret_i && !accept_i) |=> !exl_o);
  assert_accept_sets_exl_R3: assert property (@(posedge clk) disable iff (!rst_n)
    accept_i |=> (exl_o && mask_o == $past(acc_lvl_i)));
  assert_epc_capture_R6: assert property (@(posedge clk) disable iff (!rst_n)
    accept_i |=> (epc_o == $past(pc_i)));
  assert_ie_sw_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_status |=> $stable(ie_o));
endmodule

// File: rtl/irq_level_gate.sv
module irq_level_gate
  import irq_gate_pkg::*;
#(
  parameter int N_SRC = 8,
  parameter int LVL_W = 3,
  parameter int PC_W  = 32,
  localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [N_SRC-1:0]       req_i,
  input  logic [N_SRC*LVL_W-1:0] prio_i,
  input  logic                   retire_i,
  input  logic [PC_W-1:0]        pc_i,
  input  logic                   eret_i,
  input  logic                   reg_we_i,
  input  logic [1:0]             reg_addr_i,
  input  logic [PC_W-1:0]        reg_wdata_i,
  output logic [PC_W-1:0]        reg_rdata_o,
  output logic                   take_o,
  output logic [IDX_W-1:0]       take_id_o,
  output logic [LVL_W-1:0]       take_lvl_o
);
  logic             win_any;
  logic [IDX_W-1:0] win_idx;
  logic [LVL_W-1:0] win_lvl;
  logic [LVL_W-1:0] cur_mask;
  logic             cur_exl, cur_ie;
  logic [PC_W-1:0]  cur_epc;
  logic             gate_open, level_ok, accept;

  irq_pick #(.N_SRC(N_SRC), .LVL_W(LVL_W)) pick_i (
    .req_i(req_i), .prio_i(prio_i),
    .any_o(win_any), .idx_o(win_idx), .lvl_o(win_lvl)
  );

  assign gate_open = cur_ie && !cur_exl && retire_i;
  assign level_ok  = outranks(8'(win_lvl), 8'(cur_mask));
  assign accept    = gate_open && win_any && level_ok;

  irq_state #(.LVL_W(LVL_W), .PC_W(PC_W)) state_i (
    .clk(clk), .rst_n(rst_n),
    .accept_i(accept), .acc_lvl_i(win_lvl), .pc_i(pc_i), .eret_i(eret_i),
    .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
    .mask_o(cur_mask), .exl_o(cur_exl), .ie_o(cur_ie), .epc_o(cur_epc),
    .rdata_o(reg_rdata_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      take_o     <= 1'b0;
      take_id_o  <= '0;
      take_lvl_o <= '0;
    end else begin
      take_o     <= accept;
      take_id_o  <= accept ? win_idx : '0;
      take_lvl_o <= accept ? win_lvl : '0;
    end
  end

  assert_mask_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> (cur_mask == take_lvl_o));
  assert_strictly_higher_R2: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> ($past(cur_mask) < take_lvl_o));
  assert_gates_open_R5: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> ($past(cur_ie) && !$past(cur_exl) && $past(retire_i)));
  assert_single_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |=> !take_o);
  assert_winner_live_R7: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> (req_i[win_idx] && win_lvl != '0));
endmodule

// File: tb/irq_level_gate_tb.sv
module irq_level_gate_tb_top;
  localparam int N  = 8;
  localparam int LW = 3;
  localparam int PW = 32;
  localparam int IW = 3;
  localparam time CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] req = '0;
  logic [N*LW-1:0] prio = '0;
  logic retire = 1'b0, eret = 1'b0, we = 1'b0;
  logic [PW-1:0] pc = '0, wdata = '0;
  logic [1:0] addr = '0;
  logic [PW-1:0] rdata;
  logic take;
  logic [IW-1:0] take_id;
  logic [LW-1:0] take_lvl;

  int n_run = 0, n_fail = 0;
  logic [LW-1:0] m_mask;
  logic m_exl, m_ie;
  logic [PW-1:0] m_epc;
  logic e_take;
  logic [IW-1:0] e_id;
  logic [LW-1:0] e_lvl;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_level_gate #(.N_SRC(N), .LVL_W(LW), .PC_W(PW)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_i(req), .prio_i(prio), .retire_i(retire),
    .pc_i(pc), .eret_i(eret), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .take_o(take),
    .take_id_o(take_id), .take_lvl_o(take_lvl)
  );

  task automatic check(input logic [PW-1:0] act, input logic [PW-1:0] exp, input string what);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  function automatic logic [PW-1:0] exp_read(input logic [1:0] a);
    case (a)
      2'd0: return {30'd0, m_exl, m_ie};
      2'd1: return {29'd0, m_mask};
      2'd2: return m_epc;
      default: return '0;
    endcase
  endfunction

  // scan levels top-down, and indices upward within a level (R7)
  task automatic model_step();
    logic found = 1'b0;
    logic [IW-1:0] wi = '0;
    logic [LW-1:0] wl = '0;
    logic acc;
    for (int l = 7; l >= 1 && !found; l--)
      for (int i = 0; i < N && !found; i++)
        if (req[i] && prio[i*LW +: LW] == LW'(l)) begin
          found = 1'b1; wi = IW'(i); wl = LW'(l);
        end
    acc = retire && found && m_ie && !m_exl && (wl > m_mask);
    if (we && addr == 2'd0) begin m_ie = wdata[0]; m_exl = wdata[1]; end
    if (we && addr == 2'd1) m_mask = wdata[LW-1:0];
    if (eret) m_exl = 1'b0;
    if (acc) begin m_mask = wl; m_exl = 1'b1; m_epc = pc; end
    e_take = acc;
    e_id = acc ? wi : '0;
    e_lvl = acc ? wl : '0;
  endtask

  task automatic cycle(input string tag);
    @(posedge clk);
    model_step();
    #1;
    check({31'd0, take}, {31'd0, e_take}, {tag, " R2 R3 R5 R8 take"});
    check({29'd0, take_id}, {29'd0, e_id}, {tag, " R7 R10 take_id"});
    check({29'd0, take_lvl}, {29'd0, e_lvl}, {tag, " R1 R7 take_lvl"});
    check(rdata, exp_read(addr), {tag, " R9 R6 R4 rdata"});
    @(negedge clk);
    we = 1'b0; eret = 1'b0;
  endtask

  task automatic set_prio(input int i, input int l);
    prio[i*LW +: LW] = LW'(l);
  endtask

  task automatic sw_write(input logic [1:0] a, input logic [PW-1:0] d, input string tag);
    we = 1'b1; addr = a; wdata = d;
    cycle(tag);
  endtask

  task automatic read_all(input string tag);
    for (int a = 0; a < 4; a++) begin
      addr = 2'(a);
      #1;
      check(rdata, exp_read(2'(a)), {tag, " R9 read"});
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog expired R10");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd7341));
    m_mask = '0; m_exl = 1'b0; m_ie = 1'b0; m_epc = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    read_all("R11 reset");
    check({31'd0, take}, 32'd0, "R11 reset take");
    @(negedge clk);

    // ie=0 blocks a valid request
    req = 8'h01; set_prio(0, 5); retire = 1'b1; pc = 32'h100;
    cycle("R5 ie off");
    sw_write(2'd0, 32'h1, "R5 enable");
    // retire low blocks
    retire = 1'b0; cycle("R8 no retire");
    // tie at level 5: sources 2 and 6, index 2 wins
    req = 8'h44; set_prio(2, 5); set_prio(6, 5); set_prio(0, 0);
    retire = 1'b1; pc = 32'h200;
    cycle("R7 tie");
    cycle("R3 exl blocks");
    read_all("R6 epc 200");
    // nesting: clear exl, equal level rejected, higher accepted
    sw_write(2'd0, 32'h1, "R3 sw clear exl");
    req = 8'h08; set_prio(3, 5); cycle("R2 equal level");
    set_prio(3, 6); pc = 32'h300; cycle("R2 higher level");
    read_all("R6 epc overwrite");
    // level 0 never chosen; higher index wins over lower level
    sw_write(2'd0, 32'h1, "R9 reopen");
    req = 8'h81; set_prio(0, 0); set_prio(7, 7); pc = 32'h400;
    cycle("R7 level0 skipped");
    // restore mask, set exl, write epc ignored, then return
    sw_write(2'd1, 32'h2, "R9 mask write");
    sw_write(2'd2, 32'hDEAD, "R9 epc read-only");
    read_all("R9 after writes");
    req = '0; eret = 1'b1; cycle("R4 eret");
    read_all("R4 after eret");
    // write and accept at the same edge: accept wins
    req = 8'h02; set_prio(1, 4); we = 1'b1; addr = 2'd1; wdata = 32'h1;
    cycle("R9 precedence");

    for (int k = 0; k < 4000; k++) begin
      req = N'($urandom);
      prio = (N*LW)'($urandom);
      retire = ($urandom % 4) != 0;
      pc = $urandom;
      eret = ($urandom % 8) == 0;
      we = ($urandom % 5) == 0;
      addr = 2'($urandom);
      wdata = (addr == 2'd0) ? {30'd0, 1'($urandom % 2), 1'(($urandom % 6) != 0)}
                             : $urandom;
      cycle("rand");
    end
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule